// File: doc/BRIEF.md
# Descriptor-Driven Save/Restore Engine

The engine walks a contiguous block of descriptors for one group and runs either a save pass or a restore pass over registers reached through a simple memory-mapped master port. A scheduler outside the block picks the group and hands over its first and last descriptor index, the allowed target address window, the pass kind and one walk-direction bit per pass kind. A pulse on `start` latches that configuration. The engine then fetches each descriptor from a descriptor store with one cycle of read latency, executes it and steps to the next index until the end index has been handled.

Each descriptor carries a target address, a 32-bit data word and a 7-bit control field holding the operation type, the access size and separate save and restore enables. Operations copy a target into the descriptor (save) or back out of it (restore), write a fixed value, read-modify-write with OR or AND, wait a number of cycles, or poll a target until a masked bit pattern clears or appears. A target outside the window, or a non-OKAY bus response, aborts the group, sets an error flag and captures the failing descriptor index.

States: `S_IDLE`, `S_FETCH` (descriptor read issued), `S_DECODE` (descriptor decoded, window checked), `S_READ`, `S_WRITE` (bus access held until acknowledged), `S_DELAY` (counting), `S_STEP` (end test or index step), `S_DONE_OK`, `S_DONE_ERR`. Transitions: IDLE→FETCH on start; FETCH→DECODE; DECODE→STEP (disabled, reserved or zero delay), →DELAY, →READ, →WRITE, or →DONE_ERR (window miss); READ→STEP (copy or poll met), →READ (poll not met), →WRITE (OR/AND), →DONE_ERR (bus error); WRITE→STEP or →DONE_ERR; DELAY→STEP when the count expires; STEP→FETCH or →DONE_OK at the end index; both DONE states→IDLE.

Top module: `desc_sr_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `m_req`, `done`, `done_err`, `desc_wr`, `err_addr` and `err_bus` are all low.
- R2: A pass visits every index from `first_idx` to `last_idx` inclusive in rising order when its direction bit (`save_rev` for a save, `rest_rev` for a restore) is 0 and in falling order when it is 1, and ends with exactly one cycle of `done` followed by idle.
- R3: Control field bits are [2:0] type, [4:3] size, [5] save enable, [6] restore enable. A descriptor whose enable for the current pass is 0, or whose type is the reserved value 7, causes no bus access and no descriptor write.
- R4: Type 0 on a save pass reads the target and writes the size-masked value into the descriptor data word; on a restore pass it writes the stored data word to the target.
- R5: Type 1 writes the data word to the target; types 2 and 3 read the target, OR (type 2) or AND (type 3) it with the data word and write the result back; all three run in either pass when enabled.
- R6: Type 4 makes no bus access and holds the walk for exactly N cycles, N being the data word, so a one-descriptor group ends with `done` N+3 clocks after the clock that accepted `start` (3 clocks for N=0 or a skipped descriptor).
- R7: Type 5 repeats reads of the target until (read AND data) is 0; type 6 repeats until it is non-zero; neither type writes.
- R8: Size 0 drives strobes 0001 and uses data bits [7:0]; size 1 drives 0011 and bits [15:0]; sizes 2 and 3 drive 1111 and all 32 bits; read values are zero-extended to the access size.
- R9: A non-delay enabled descriptor whose target lies outside `win_lo`..`win_hi` (both inclusive) makes no access, sets `err_addr`, captures its index on `err_idx`, and ends the pass with one cycle of `done_err`.
- R10: A bus response with `m_err` set aborts the pass after that access, sets `err_bus`, captures the descriptor index on `err_idx` and ends with one cycle of `done_err`.
- R11: `start` while busy is ignored; a new accepted `start` clears both error flags.
- R12: Once raised, `m_req` stays high with address, direction and write data unchanged until `m_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (accepted only when idle) |
| restore | input | 1 | 1 = restore pass, 0 = save pass |
| save_rev | input | 1 | Walk direction for save passes (1 = end to start) |
| rest_rev | input | 1 | Walk direction for restore passes |
| first_idx | input | IDX_W | Lowest descriptor index of the group |
| last_idx | input | IDX_W | Highest descriptor index of the group |
| win_lo | input | AW | Lowest permitted target address |
| win_hi | input | AW | Highest permitted target address |
| desc_rd | output | 1 | Descriptor read strobe |
| desc_idx | output | IDX_W | Descriptor index for read and write |
| desc_tgt | input | AW | Target address of the fetched descriptor |
| desc_data | input | 32 | Data word of the fetched descriptor |
| desc_ctl | input | 7 | Control field of the fetched descriptor |
| desc_wr | output | 1 | Descriptor data-word write strobe |
| desc_wdata | output | 32 | Value written into the data word |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | Bus direction (1 = write) |
| m_addr | output | AW | Bus address |
| m_wdata | output | 32 | Bus write data |
| m_strb | output | 4 | Bus byte strobes |
| m_ack | input | 1 | Bus access complete |
| m_rdata | input | 32 | Bus read data, valid with m_ack |
| m_err | input | 1 | Non-OKAY response, valid with m_ack |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse: pass finished cleanly |
| done_err | output | 1 | One-cycle pulse: pass aborted |
| err_addr | output | 1 | Window violation seen in the last pass |
| err_bus | output | 1 | Bus error seen in the last pass |
| err_idx | output | IDX_W | Index of the descriptor that failed |

## Verification
A wrong index, direction or end register shows as the first bus access that differs from the predicted sequence, which is compared the cycle it completes, or as a missing or extra access before `done`. A wrong latched descriptor field or read-modify-write result shows in the address, strobe or data of the very next access, or in the descriptor store and register contents compared at the end of the pass. A mis-loaded delay counter shifts `done` by a measurable number of clocks, and a wrong error-capture register shows on `err_idx` and the error flags in the `done_err` cycle.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int DATA_W  = 32;
    localparam int STRB_W  = DATA_W / 8;
    localparam int CTL_W   = 7;
    localparam int OP_LSB  = 0;
    localparam int SZ_LSB  = 3;
    localparam int SV_BIT  = 5;
    localparam int RT_BIT  = 6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_READ,
        S_WRITE,
        S_DELAY,
        S_STEP,
        S_DONE_OK,
        S_DONE_ERR
    } sr_state_e;

    typedef enum logic [2:0] {
        OP_COPY     = 3'd0,
        OP_FIXED    = 3'd1,
        OP_OR       = 3'd2,
        OP_AND      = 3'd3,
        OP_WAIT     = 3'd4,
        OP_POLL_CLR = 3'd5,
        OP_POLL_SET = 3'd6,
        OP_RSVD     = 3'd7
    } sr_op_e;

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [STRB_W-1:0] size_strb(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/sr_idx_step.sv
module sr_idx_step #(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] cur,
    input  logic [IDX_W-1:0] stop,
    input  logic             rev,
    output logic [IDX_W-1:0] nxt,
    output logic             at_end
);
    always_comb begin
        nxt    = rev ? (cur - IDX_W'(1)) : (cur + IDX_W'(1));
        at_end = (cur == stop);
    end
endmodule

// File: rtl/sr_op_unit.sv
module sr_op_unit
    import sr_pkg::*;
(
    input  sr_op_e              op,
    input  logic [1:0]          sz,
    input  logic [DATA_W-1:0]   rd_raw,
    input  logic [DATA_W-1:0]   operand,
    output logic [DATA_W-1:0]   rd_val,
    output logic [DATA_W-1:0]   rmw_val,
    output logic [STRB_W-1:0]   strb,
    output logic                poll_met
);
    logic [DATA_W-1:0] msk;
    logic [DATA_W-1:0] hit;

    always_comb begin
        msk     = size_mask(sz);
        strb    = size_strb(sz);
        rd_val  = rd_raw & msk;
        rmw_val = ((op == OP_OR) ? (rd_val | operand) : (rd_val & operand)) & msk;
        hit     = rd_val & operand;
        poll_met = (op == OP_POLL_CLR) ? (hit == '0) : (hit != '0);
    end
endmodule

// File: rtl/desc_sr_engine.sv
module desc_sr_engine
    import sr_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int AW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                restore,
    input  logic                save_rev,
    input  logic                rest_rev,
    input  logic [IDX_W-1:0]    first_idx,
    input  logic [IDX_W-1:0]    last_idx,
    input  logic [AW-1:0]       win_lo,
    input  logic [AW-1:0]       win_hi,
    output logic                desc_rd,
    output logic [IDX_W-1:0]    desc_idx,
    input  logic [AW-1:0]       desc_tgt,
    input  logic [31:0]         desc_data,
    input  logic [6:0]          desc_ctl,
    output logic                desc_wr,
    output logic [31:0]         desc_wdata,
    output logic                m_req,
    output logic                m_we,
    output logic [AW-1:0]       m_addr,
    output logic [31:0]         m_wdata,
    output logic [3:0]          m_strb,
    input  logic                m_ack,
    input  logic [31:0]         m_rdata,
    input  logic                m_err,
    output logic                busy,
    output logic                done,
    output logic                done_err,
    output logic                err_addr,
    output logic                err_bus,
    output logic [IDX_W-1:0]    err_idx
);
    sr_state_e          state_q, state_d;

    logic               rest_q, rev_q;
    logic [IDX_W-1:0]   idx_q, endi_q, err_idx_q;
    logic [AW-1:0]      lo_q, hi_q, tgt_q;
    logic [DATA_W-1:0]  dat_q, wv_q, cnt_q;
    sr_op_e             op_q;
    logic [1:0]         sz_q;
    logic               err_addr_q, err_bus_q;

    logic ld_cfg, ld_desc, ld_rmw, cnt_dec, adv, set_aerr, set_berr;

    sr_op_e             d_op;
    logic [1:0]         d_sz;
    logic               pass_en, in_win;

    logic [IDX_W-1:0]   idx_nxt;
    logic               idx_last;
    logic [DATA_W-1:0]  rd_val, rmw_val;
    logic [STRB_W-1:0]  strb;
    logic               poll_met;

    sr_idx_step #(.IDX_W(IDX_W)) u_step (
        .cur    (idx_q),
        .stop   (endi_q),
        .rev    (rev_q),
        .nxt    (idx_nxt),
        .at_end (idx_last)
    );

    sr_op_unit u_op (
        .op       (op_q),
        .sz       (sz_q),
        .rd_raw   (m_rdata),
        .operand  (dat_q),
        .rd_val   (rd_val),
        .rmw_val  (rmw_val),
        .strb     (strb),
        .poll_met (poll_met)
    );

    // descriptor decode, valid while in S_DECODE
    always_comb begin
        d_op    = sr_op_e'(desc_ctl[OP_LSB +: 3]);
        d_sz    = desc_ctl[SZ_LSB +: 2];
        pass_en = rest_q ? desc_ctl[RT_BIT] : desc_ctl[SV_BIT];
        in_win  = (desc_tgt >= lo_q) && (desc_tgt <= hi_q);
    end

    // next state and control strobes
    always_comb begin
        state_d  = state_q;
        ld_cfg   = 1'b0;
        ld_desc  = 1'b0;
        ld_rmw   = 1'b0;
        cnt_dec  = 1'b0;
        adv      = 1'b0;
        set_aerr = 1'b0;
        set_berr = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    ld_cfg  = 1'b1;
                    state_d = S_FETCH;
                end
            end
            S_FETCH: state_d = S_DECODE;
            S_DECODE: begin
                ld_desc = 1'b1;
                if (!pass_en || d_op == OP_RSVD) begin
                    state_d = S_STEP;
                end else if (d_op == OP_WAIT) begin
                    state_d = (desc_data == '0) ? S_STEP : S_DELAY;
                end else if (!in_win) begin
                    set_aerr = 1'b1;
                    state_d  = S_DONE_ERR;
                end else if (d_op == OP_FIXED || (d_op == OP_COPY && rest_q)) begin
                    state_d = S_WRITE;
                end else begin
                    state_d = S_READ;
                end
            end
            S_READ: begin
                if (m_ack) begin
                    if (m_err) begin
                        set_berr = 1'b1;
                        state_d  = S_DONE_ERR;
                    end else begin
                        unique case (op_q)
                            OP_OR, OP_AND: begin
                                ld_rmw  = 1'b1;
                                state_d = S_WRITE;
                            end
                            OP_POLL_CLR, OP_POLL_SET:
                                state_d = poll_met ? S_STEP : S_READ;
                            default: state_d = S_STEP;
                        endcase
                    end
                end
            end
            S_WRITE: begin
                if (m_ack) begin
                    if (m_err) begin
                        set_berr = 1'b1;
                        state_d  = S_DONE_ERR;
                    end else begin
                        state_d = S_STEP;
                    end
                end
            end
            S_DELAY: begin
                if (cnt_q == DATA_W'(1)) state_d = S_STEP;
                else                     cnt_dec = 1'b1;
            end
            S_STEP: begin
                if (idx_last) begin
                    state_d = S_DONE_OK;
                end else begin
                    adv     = 1'b1;
                    state_d = S_FETCH;
                end
            end
            S_DONE_OK:  state_d = S_IDLE;
            S_DONE_ERR: state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rest_q     <= 1'b0;
            rev_q      <= 1'b0;
            idx_q      <= '0;
            endi_q     <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            tgt_q      <= '0;
            dat_q      <= '0;
            wv_q       <= '0;
            cnt_q      <= '0;
            op_q       <= OP_COPY;
            sz_q       <= 2'd0;
            err_addr_q <= 1'b0;
            err_bus_q  <= 1'b0;
            err_idx_q  <= '0;
        end else begin
            if (ld_cfg) begin
                rest_q     <= restore;
                rev_q      <= restore ? rest_rev : save_rev;
                idx_q      <= (restore ? rest_rev : save_rev) ? last_idx : first_idx;
                endi_q     <= (restore ? rest_rev : save_rev) ? first_idx : last_idx;
                lo_q       <= win_lo;
                hi_q       <= win_hi;
                err_addr_q <= 1'b0;
                err_bus_q  <= 1'b0;
            end
            if (ld_desc) begin
                tgt_q <= desc_tgt;
                dat_q <= desc_data;
                op_q  <= d_op;
                sz_q  <= d_sz;
                wv_q  <= desc_data & size_mask(d_sz);
                cnt_q <= desc_data;
            end
            if (ld_rmw)  wv_q  <= rmw_val;
            if (cnt_dec) cnt_q <= cnt_q - DATA_W'(1);
            if (adv)     idx_q <= idx_nxt;
            if (set_aerr) begin
                err_addr_q <= 1'b1;
                err_idx_q  <= idx_q;
            end
            if (set_berr) begin
                err_bus_q <= 1'b1;
                err_idx_q <= idx_q;
            end
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_DONE_OK);
        done_err   = (state_q == S_DONE_ERR);
        desc_rd    = (state_q == S_FETCH);
        desc_idx   = idx_q;
        desc_wr    = (state_q == S_READ) && m_ack && !m_err && (op_q == OP_COPY);
        desc_wdata = rd_val;
        m_req      = (state_q == S_READ) || (state_q == S_WRITE);
        m_we       = (state_q == S_WRITE);
        m_addr     = tgt_q;
        m_wdata    = wv_q;
        m_strb     = strb;
        err_addr   = err_addr_q;
        err_bus    = err_bus_q;
        err_idx    = err_idx_q;
    end

endmodule

// File: rtl/sr_engine_chk.sv
module sr_engine_chk
    import sr_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int AW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             done_err,
    input logic             desc_wr,
    input logic             m_req,
    input logic             m_we,
    input logic             m_ack,
    input logic [AW-1:0]    m_addr,
    input logic [31:0]      m_wdata,
    input logic [3:0]       m_strb,
    input logic             err_addr,
    input logic             err_bus,
    input logic [AW-1:0]    lo_q,
    input logic [AW-1:0]    hi_q,
    input logic [IDX_W-1:0] endi_q,
    input sr_op_e           op_q
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!m_req && !desc_wr));

    p_one_end_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && done_err));

    p_end_then_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done || done_err) |=> !busy);

    p_poll_wait_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> (op_q == OP_COPY || op_q == OP_FIXED ||
                             op_q == OP_OR   || op_q == OP_AND));

    p_strobe_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> (m_strb == 4'b0001 || m_strb == 4'b0011 || m_strb == 4'b1111));

    p_inside_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> (m_addr >= lo_q && m_addr <= hi_q));

    p_abort_flagged_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> (err_addr || err_bus));

    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(lo_q) && $stable(hi_q) && $stable(endi_q)));

    p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

endmodule

bind desc_sr_engine sr_engine_chk #(.IDX_W(IDX_W), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .done_err (done_err),
    .desc_wr  (desc_wr),
    .m_req    (m_req),
    .m_we     (m_we),
    .m_ack    (m_ack),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .m_strb   (m_strb),
    .err_addr (err_addr),
    .err_bus  (err_bus),
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .endi_q   (endi_q),
    .op_q     (op_q)
);

// File: tb/desc_sr_engine_tb.sv
`timescale 1ns/1ps
module desc_sr_engine_tb_top;

    localparam logic [31:0] LO_A   = 32'h0000_0100;
    localparam logic [31:0] HI_A   = 32'h0000_01FC;
    localparam logic [31:0] POLL_A = 32'h0000_01F0;
    localparam logic [31:0] BERR_A = 32'h0000_01E0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start = 1'b0, restore = 1'b0, save_rev = 1'b0, rest_rev = 1'b0;
    logic [9:0]  first_idx = '0, last_idx = '0;
    logic [31:0] win_lo = LO_A, win_hi = HI_A;
    logic        desc_rd, desc_wr;
    logic [9:0]  desc_idx, err_idx;
    logic [31:0] desc_tgt = '0, desc_data = '0, desc_wdata;
    logic [6:0]  desc_ctl = '0;
    logic        m_req, m_we, m_ack = 1'b0, m_err = 1'b0;
    logic [31:0] m_addr, m_wdata, m_rdata = '0;
    logic [3:0]  m_strb;
    logic        busy, done, done_err, err_addr, err_bus;

    desc_sr_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .restore(restore),
        .save_rev(save_rev), .rest_rev(rest_rev),
        .first_idx(first_idx), .last_idx(last_idx), .win_lo(win_lo), .win_hi(win_hi),
        .desc_rd(desc_rd), .desc_idx(desc_idx), .desc_tgt(desc_tgt),
        .desc_data(desc_data), .desc_ctl(desc_ctl),
        .desc_wr(desc_wr), .desc_wdata(desc_wdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_strb(m_strb), .m_ack(m_ack), .m_rdata(m_rdata), .m_err(m_err),
        .busy(busy), .done(done), .done_err(done_err),
        .err_addr(err_addr), .err_bus(err_bus), .err_idx(err_idx)
    );

    // ---------------- models ----------------
    logic [31:0] d_tgt [64];
    logic [31:0] d_data[64];
    logic [6:0]  d_ctl [64];
    logic [31:0] regs  [64];
    logic [31:0] sh_regs[64];
    logic [31:0] pd_data[64];
    int poll_left = 0;
    int sh_poll;

    typedef struct {
        bit          we;
        logic [31:0] a;
        logic [31:0] wd;
        logic [3:0]  st;
        string       tag;
    } tx_t;
    tx_t exq[$];

    int nchk = 0, nfail = 0;
    bit ended = 0;
    bit exp_ea, exp_eb;
    int exp_ei;

    function automatic int widx(logic [31:0] a);
        return int'((a - LO_A) >> 2) & 63;
    endfunction
    function automatic logic [31:0] msk_of(logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic logic [3:0] be_of(logic [1:0] s);
        return (s == 2'd0) ? 4'b0001 : (s == 2'd1) ? 4'b0011 : 4'b1111;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // descriptor store, one cycle read latency
    always @(posedge clk) begin
        if (desc_rd) begin
            desc_tgt  <= d_tgt [desc_idx[5:0]];
            desc_data <= d_data[desc_idx[5:0]];
            desc_ctl  <= d_ctl [desc_idx[5:0]];
        end
        if (desc_wr) d_data[desc_idx[5:0]] <= desc_wdata;
    end

    // register-file bus model: ack in the second cycle of each request
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack <= 1'b0;
        end else if (m_req && m_ack) begin
            m_ack <= 1'b0;
            if (m_we && m_addr != BERR_A)
                for (int b = 0; b < 4; b++)
                    if (m_strb[b]) regs[widx(m_addr)][8*b +: 8] <= m_wdata[8*b +: 8];
        end else if (m_req) begin
            m_ack <= 1'b1;
            m_err <= (m_addr == BERR_A);
            if (m_addr == POLL_A) begin
                m_rdata <= (poll_left > 0) ? 32'd1 : 32'd2;
                if (!m_we && poll_left > 0) poll_left = poll_left - 1;
            end else begin
                m_rdata <= regs[widx(m_addr)];
            end
        end
    end

    // per-clock comparison of completed accesses and request holding
    logic        pend = 1'b0;
    logic [31:0] pend_a;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend)
                check(m_req && m_addr == pend_a, "R12", "request held until ack", m_addr, pend_a);
            pend   = m_req && !m_ack;
            pend_a = m_addr;
            if (m_req && m_ack) begin
                if (exq.size() == 0) begin
                    check(1'b0, "R2", "unexpected bus access", m_addr, 32'h0);
                end else begin
                    tx_t t;
                    t = exq.pop_front();
                    check(m_we == t.we && m_addr == t.a, t.tag, "access direction/address",
                          {m_we, m_addr[30:0]}, {t.we, t.a[30:0]});
                    check(m_strb == t.st, "R8", "byte strobes", 32'(m_strb), 32'(t.st));
                    if (t.we) check(m_wdata == t.wd, t.tag, "write data", m_wdata, t.wd);
                end
            end
        end
    end

    // ---------------- behavioural predictor ----------------
    task automatic exp_rd(logic [31:0] a, logic [1:0] sz, string tag,
                          output logic [31:0] v, output bit e);
        tx_t t;
        t.we = 0; t.a = a; t.wd = '0; t.st = be_of(sz); t.tag = tag;
        exq.push_back(t);
        e = (a == BERR_A);
        if (a == POLL_A) begin
            v = (sh_poll > 0) ? 32'd1 : 32'd2;
            if (sh_poll > 0) sh_poll--;
        end else begin
            v = sh_regs[widx(a)];
        end
        v = v & msk_of(sz);
    endtask

    task automatic exp_wr(logic [31:0] a, logic [31:0] wd, logic [1:0] sz, string tag,
                          output bit e);
        tx_t t;
        t.we = 1; t.a = a; t.wd = wd & msk_of(sz); t.st = be_of(sz); t.tag = tag;
        exq.push_back(t);
        e = (a == BERR_A);
        if (!e)
            for (int b = 0; b < 4; b++)
                if (t.st[b]) sh_regs[widx(a)][8*b +: 8] = t.wd[8*b +: 8];
    endtask

    task automatic predict(bit rs, int first, int last, bit rev);
        int i, stop;
        i = rev ? last : first;
        stop = rev ? first : last;
        exp_ea = 0; exp_eb = 0; exp_ei = 0;
        forever begin
            logic [6:0]  c;
            logic [2:0]  op;
            logic [1:0]  sz;
            logic [31:0] v, a, d;
            bit          e, en, ok;
            c = d_ctl[i]; op = c[2:0]; sz = c[4:3]; a = d_tgt[i]; d = pd_data[i];
            en = rs ? c[6] : c[5];
            e = 0;
            if (en && op != 3'd7 && op != 3'd4) begin
                if (a < LO_A || a > HI_A) begin
                    exp_ea = 1; exp_ei = i;
                    break;
                end
                case (op)
                    3'd0: if (!rs) begin
                              exp_rd(a, sz, "R4", v, e);
                              if (!e) pd_data[i] = v;
                          end else exp_wr(a, d, sz, "R4", e);
                    3'd1: exp_wr(a, d, sz, "R5", e);
                    3'd2, 3'd3: begin
                        exp_rd(a, sz, "R5", v, e);
                        if (!e) exp_wr(a, (op == 3'd2) ? (v | d) : (v & d), sz, "R5", e);
                    end
                    default: begin
                        ok = 0;
                        while (!ok && !e) begin
                            exp_rd(a, sz, "R7", v, e);
                            ok = (op == 3'd5) ? ((v & d) == 0) : ((v & d) != 0);
                        end
                    end
                endcase
                if (e) begin
                    exp_eb = 1; exp_ei = i;
                    break;
                end
            end
            if (i == stop) break;
            i = rev ? i - 1 : i + 1;
        end
    endtask

    task automatic set_desc(int i, logic [31:0] t, logic [31:0] d, int op, int sz, bit sv, bit rt);
        d_tgt[i] = t; d_data[i] = d;
        d_ctl[i] = {rt, sv, 2'(sz), 3'(op)};
    endtask

    // run one pass and compare end state; returns clocks from start accept to end pulse
    task automatic run_group(bit rs, int first, int last, bit rev, bit inject, output int cyc);
        bit hung;
        for (int k = 0; k < 64; k++) begin
            sh_regs[k] = regs[k];
            pd_data[k] = d_data[k];
        end
        sh_poll = poll_left;
        predict(rs, first, last, rev);
        @(negedge clk);
        restore = rs; save_rev = rev; rest_rev = rev;
        first_idx = 10'(first); last_idx = 10'(last); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0; hung = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = 1'b0;
            if (done || done_err) break;
            if (inject && cyc == 4) begin
                // R11: second start while busy must be ignored
                start = 1'b1; restore = !rs; first_idx = 10'd20; last_idx = 10'd22;
            end
            if (cyc > 3000) begin hung = 1; break; end
        end
        check(!hung, "R2", "pass ended", 32'(cyc), 32'd3000);
        check(done == !(exp_ea || exp_eb), "R2", "done pulse", 32'(done), 32'(!(exp_ea || exp_eb)));
        check(done_err == (exp_ea || exp_eb), "R10", "done_err pulse", 32'(done_err), 32'(exp_ea || exp_eb));
        check(err_addr == exp_ea, "R9", "address error flag", 32'(err_addr), 32'(exp_ea));
        check(err_bus == exp_eb, "R10", "bus error flag", 32'(err_bus), 32'(exp_eb));
        if (exp_ea || exp_eb)
            check(err_idx == 10'(exp_ei), "R9", "failing index", 32'(err_idx), 32'(exp_ei));
        check(exq.size() == 0, "R2", "accesses left unmade", 32'(exq.size()), 32'd0);
        exq.delete();
        @(negedge clk);
        check(!busy, "R2", "idle after end pulse", 32'(busy), 32'd0);
        for (int k = 0; k < 64; k++) begin
            if (regs[k] != sh_regs[k])
                check(1'b0, "R5", $sformatf("register %0d contents", k), regs[k], sh_regs[k]);
            if (d_data[k] != pd_data[k])
                check(1'b0, "R4", $sformatf("descriptor %0d data", k), d_data[k], pd_data[k]);
        end
        nchk += 2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            nfail++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int k = 0; k < 64; k++) begin
            regs[k]   = {8'(k * 3 + 1), 8'(k * 5 + 2), 8'(k * 7 + 3), 8'(k * 11 + 4)};
            d_tgt[k]  = LO_A;
            d_data[k] = '0;
            d_ctl[k]  = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!busy && !m_req && !desc_wr, "R1", "idle outputs after reset", {29'd0, busy, m_req, desc_wr}, 32'd0);
        check(!done && !done_err && !err_addr && !err_bus, "R1", "no end pulse or flags",
              {28'd0, done, done_err, err_addr, err_bus}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // save pass, rising order; sizes 32/16/8; idx 3 save-disabled (R3)
        set_desc(0, 32'h104, 32'h0,         0, 2, 1, 1);
        set_desc(1, 32'h108, 32'h0,         0, 1, 1, 1);
        set_desc(2, 32'h10C, 32'h0,         0, 0, 1, 1);
        set_desc(3, 32'h110, 32'h0BAD_F00D, 0, 2, 0, 1);
        set_desc(4, 32'h114, 32'hDEAD_BEEF, 1, 2, 1, 0);
        run_group(0, 0, 4, 0, 0, cyc);

        // restore pass, falling order; idx 4 restore-disabled (R3)
        regs[1] = '0; regs[2] = '0; regs[3] = '0; regs[4] = '0;
        run_group(1, 0, 4, 1, 0, cyc);

        // OR / AND / fixed byte write / delay / reserved type
        set_desc(8,  32'h120, 32'h00F0_000F, 2, 2, 1, 0);
        set_desc(9,  32'h124, 32'h0000_FF00, 3, 1, 1, 0);
        set_desc(10, 32'h128, 32'hABCD_EF5A, 1, 0, 1, 0);
        set_desc(11, 32'h100, 32'd5,         4, 2, 1, 0);
        set_desc(12, 32'h12C, 32'h1111_1111, 7, 2, 1, 1);
        run_group(0, 8, 12, 0, 0, cyc);

        // polling in a restore pass plus a restore-pass OR
        poll_left = 3;
        set_desc(16, POLL_A,  32'd1,  5, 2, 0, 1);
        set_desc(17, POLL_A,  32'd2,  6, 2, 0, 1);
        set_desc(18, 32'h130, 32'h80, 2, 0, 0, 1);
        run_group(1, 16, 18, 0, 0, cyc);

        // R9: window miss at idx 21; upper window edge accepted at idx 20
        set_desc(20, HI_A,    32'h0,  0, 2, 1, 0);
        set_desc(21, 32'h200, 32'h55, 1, 2, 1, 0);
        set_desc(22, 32'h140, 32'h0,  0, 2, 1, 0);
        run_group(0, 20, 22, 0, 0, cyc);

        // R10: bus error at idx 25 in a falling-order save pass
        set_desc(26, 32'h150, 32'h0,  0, 2, 1, 0);
        set_desc(25, BERR_A,  32'h5,  1, 2, 1, 0);
        set_desc(24, 32'h154, 32'h77, 1, 2, 1, 0);
        run_group(0, 24, 26, 1, 0, cyc);

        // R11: start while busy ignored; new start cleared error flags
        run_group(0, 8, 12, 0, 1, cyc);

        // R6: delay timing
        set_desc(30, 32'h100, 32'd10, 4, 2, 1, 0);
        run_group(0, 30, 30, 0, 0, cyc);
        check(cyc == 13, "R6", "delay of 10 cycles end clock", 32'(cyc), 32'd13);
        set_desc(31, 32'h100, 32'd10, 4, 2, 0, 1);
        run_group(0, 31, 31, 0, 0, cyc);
        check(cyc == 3, "R6", "skipped delay end clock", 32'(cyc), 32'd3);

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule